// File: doc/BRIEF.md
# Vector Whole-Register Byte Shifter

This block moves every byte of a 128-bit vector toward one end of the register by a whole number of byte positions. The bytes left empty are filled with zeros. It is purely combinational. It decodes a 32-bit instruction word, which picks the direction and carries the shift distance in an immediate field. It also extracts the destination register index so that a later stage can route the result.

The immediate field is five bits wide, but only its lower four bits set the distance. An immediate of 16 to 31 therefore behaves exactly like the value 16 lower. It does not clear the vector. The source register field of the instruction is only decoded. The vector itself arrives on its own port, so that field has no effect on the result.

Top module: `vbyte_shift_unit`

## Requirements
- R1: An instruction whose bits [31:15] equal 17'b0111_0010_1000_1110_0 is accepted: `vld` is 1 and the vector moves toward the most significant end.
- R2: An instruction whose bits [31:15] equal 17'b0111_0010_1000_1110_1 is accepted: `vld` is 1 and the vector moves toward the least significant end.
- R3: Any other value of bits [31:15] gives `vld` = 0 and `res_vec` = 0.
- R4: For a left move by n bytes, byte i of `res_vec` equals byte i-n of `src_vec` when i >= n, and is zero otherwise.
- R5: For a right move by n bytes, byte i of `res_vec` equals byte i+n of `src_vec` when i+n <= 15, and is zero otherwise.
- R6: The distance n is bits [13:10] of the instruction. Bit 14 is ignored, so immediates 16 to 31 give the same result as immediates 0 to 15.
- R7: A distance of 0 passes `src_vec` through unchanged in either direction.
- R8: For a distance of 8 or more, the low 64-bit half of a left result is zero and the high half holds source bytes shifted up from the low half. A right result mirrors this.
- R9: `dst_idx` always equals instruction bits [4:0].
- R10: Instruction bits [9:5], the source register field, have no effect on `res_vec` or `vld`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| instr | input | 32 | Instruction word to decode |
| src_vec | input | 128 | Source vector |
| res_vec | output | 128 | Shifted vector, zero when not accepted |
| vld | output | 1 | Instruction is one of the two byte moves |
| dst_idx | output | 5 | Destination register index |

## Verification
The hardest case to reach is the wrap of the immediate. A value of 16 or more must not reach the shifter as a large distance. Bit 14 must simply be dropped, and a bench that tries only small distances never exercises this. The stimulus sweeps all 32 immediates in both directions and compares each result against a model. It also compares the result for each immediate at 16 or above with the result for the same immediate 16 lower. The source-vector pattern has a distinct nonzero value in every byte, so that a shift of 15 bytes still shows a surviving byte.

// File: rtl/vbs_pkg.sv
package vbs_pkg;
    localparam int VEC_BYTES = 16;
    localparam int VEC_W     = VEC_BYTES * 8;
    localparam int AMT_W     = $clog2(VEC_BYTES);
    localparam int IDX_W     = 5;
    localparam int OPC_W     = 17;
    localparam logic [OPC_W-1:0] OPC_MOVE_UP   = 17'b0111_0010_1000_1110_0;
    localparam logic [OPC_W-1:0] OPC_MOVE_DOWN = 17'b0111_0010_1000_1110_1;

    typedef enum logic [1:0] {
        DIR_NONE = 2'd0,
        DIR_UP   = 2'd1,
        DIR_DOWN = 2'd2
    } dir_e;
endpackage

// File: rtl/vbs_decode.sv
module vbs_decode
    import vbs_pkg::*;
(
    input  logic [31:0]      instr,
    output dir_e             dir,
    output logic [AMT_W-1:0] amt,
    output logic [IDX_W-1:0] dst
);
    logic [OPC_W-1:0] opc;

    always_comb begin
        opc = instr[31:15];
        unique case (opc)
            OPC_MOVE_UP:   dir = DIR_UP;
            OPC_MOVE_DOWN: dir = DIR_DOWN;
            default:       dir = DIR_NONE;
        endcase
        // only the low bits of the immediate count; the top bit wraps away
        amt = instr[10 +: AMT_W];
        dst = instr[IDX_W-1:0];
    end
endmodule

// File: rtl/vbs_barrel.sv
module vbs_barrel
    import vbs_pkg::*;
#(
    parameter int BYTES = VEC_BYTES,
    localparam int W    = BYTES * 8,
    localparam int AW   = $clog2(BYTES)
) (
    input  logic [W-1:0]  din,
    input  logic [AW-1:0] amt,
    input  logic          down,
    output logic [W-1:0]  dout
);
    logic [W-1:0] stg [AW+1];

    assign stg[0] = din;

    generate
        for (genvar k = 0; k < AW; k++) begin : g_stage
            localparam int SH = 8 << k;
            logic [W-1:0] moved;
            always_comb begin
                if (down) moved = stg[k] >> SH;
                else      moved = stg[k] << SH;
            end
            assign stg[k+1] = amt[k] ? moved : stg[k];
        end
    endgenerate

    assign dout = stg[AW];
endmodule

// File: rtl/vbyte_shift_unit.sv
module vbyte_shift_unit
    import vbs_pkg::*;
(
    input  logic [31:0]      instr,
    input  logic [VEC_W-1:0] src_vec,
    output logic [VEC_W-1:0] res_vec,
    output logic             vld,
    output logic [4:0]       dst_idx
);
    localparam int HALF = VEC_W / 2;

    dir_e             dir;
    logic [AMT_W-1:0] amt;
    logic [VEC_W-1:0] shifted;

    vbs_decode i_dec (
        .instr (instr),
        .dir   (dir),
        .amt   (amt),
        .dst   (dst_idx)
    );

    vbs_barrel #(.BYTES(VEC_BYTES)) i_bar (
        .din  (src_vec),
        .amt  (amt),
        .down (dir == DIR_DOWN),
        .dout (shifted)
    );

    always_comb begin
        vld     = (dir != DIR_NONE);
        res_vec = vld ? shifted : '0;
    end

    always_comb begin
        if (!$isunknown(instr) && !$isunknown(src_vec)) begin
            // R3: rejected word yields an all-zero vector
            a_r3_reject_zero: assert (vld || res_vec == '0);
            // R7: zero distance leaves the vector untouched
            a_r7_zero_pass: assert (!vld || amt != '0 || res_vec == src_vec);
            // R4: a left move by at least one byte zeroes byte 0
            a_r4_low_fill: assert (!(dir == DIR_UP && amt != '0) || res_vec[7:0] == 8'h00);
            // R5: a right move by at least one byte zeroes the top byte
            a_r5_high_fill: assert (!(dir == DIR_DOWN && amt != '0) || res_vec[VEC_W-1 -: 8] == 8'h00);
            // R8: large distances empty one half entirely
            a_r8_half_zero: assert (amt < AMT_W'(VEC_BYTES/2)
                                    || (dir == DIR_UP   && res_vec[HALF-1:0] == '0)
                                    || (dir == DIR_DOWN && res_vec[VEC_W-1:HALF] == '0)
                                    || dir == DIR_NONE);
        end
    end
endmodule

// File: tb/test_vbyte_shift_unit.sv
module test_vbyte_shift_unit;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [31:0]  instr = 32'h0;
    logic [127:0] src_vec = '0;
    logic [127:0] res_vec;
    logic         vld;
    logic [4:0]   dst_idx;
    int n_chk = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    vbyte_shift_unit i_vbyte_shift_unit (
        .instr(instr), .src_vec(src_vec), .res_vec(res_vec),
        .vld(vld), .dst_idx(dst_idx)
    );

    localparam logic [127:0] PAT = 128'h100F0E0D_0C0B0A09_08070605_04030201;
    localparam int NT = 9;
    // {right, imm}
    localparam logic [5:0] T_OP [NT] = '{6'd1, 6'd33, 6'd8, 6'd40, 6'd15, 6'd47, 6'd17, 6'd56, 6'd16};
    localparam logic [127:0] T_EXP [NT] = '{
        128'h0F0E0D0C_0B0A0908_07060504_03020100,
        128'h00100F0E_0D0C0B0A_09080706_05040302,
        128'h08070605_04030201_00000000_00000000,
        128'h00000000_00000000_100F0E0D_0C0B0A09,
        128'h01000000_00000000_00000000_00000000,
        128'h00000000_00000000_00000000_00000010,
        128'h0F0E0D0C_0B0A0908_07060504_03020100,
        128'h00000000_00000000_100F0E0D_0C0B0A09,
        PAT
    };
    localparam string T_REQ [NT] = '{"R4", "R5", "R8", "R8", "R4", "R5", "R6", "R6", "R7"};

    function automatic logic [31:0] mk(input logic right, input logic [4:0] imm,
                                       input logic [4:0] vj, input logic [4:0] vd);
        return {16'b0111_0010_1000_1110, right, imm, vj, vd};
    endfunction

    function automatic logic [127:0] model(input logic right, input logic [4:0] imm,
                                           input logic [127:0] s);
        int n = int'(imm) % 16;
        logic [127:0] r = '0;
        for (int b = 0; b < 16; b++) begin
            if (!right && b >= n)      r[b*8 +: 8] = s[(b-n)*8 +: 8];
            if (right && b + n <= 15)  r[b*8 +: 8] = s[(b+n)*8 +: 8];
        end
        return r;
    endfunction

    task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic apply(input logic [31:0] w, input logic [127:0] s);
        @(negedge clk);
        instr = w;
        src_vec = s;
        @(posedge clk);
        #2;
    endtask

    initial begin
        #1_000_000;
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [127:0] lo_r;
        repeat (3) @(posedge clk);
        #2;
        // reset state: instr = 0 is not a byte move (R3)
        chk("R3", {127'b0, vld}, 128'd0);
        chk("R3", res_vec, 128'd0);
        rst_n = 1'b1;

        for (int t = 0; t < NT; t++) begin
            apply(mk(T_OP[t][5], T_OP[t][4:0], 5'd3, 5'd7), PAT);
            chk(T_REQ[t], res_vec, T_EXP[t]);
            chk(T_OP[t][5] ? "R2" : "R1", {127'b0, vld}, 128'd1);
        end

        // R6 sweep: every immediate, both directions, and wrap equality
        for (int d = 0; d < 2; d++) begin
            for (int im = 0; im < 32; im++) begin
                apply(mk(d[0], im[4:0], 5'd1, 5'd2), PAT);
                chk("R6", res_vec, model(d[0], im[4:0], PAT));
                if (im < 16) lo_r = res_vec;
                apply(mk(d[0], 5'(im ^ 16), 5'd1, 5'd2), PAT);
                if (im < 16) chk("R6", res_vec, lo_r);
            end
        end

        // R7 with an all-ones source in both directions
        apply(mk(1'b0, 5'd0, 5'd0, 5'd0), '1);
        chk("R7", res_vec, '1);
        apply(mk(1'b1, 5'd16, 5'd0, 5'd0), '1);
        chk("R7", res_vec, '1);

        // R3: neighbouring opcodes are rejected
        apply(mk(1'b0, 5'd3, 5'd4, 5'd5) ^ 32'h0001_0000, PAT);
        chk("R3", {127'b0, vld}, 128'd0);
        chk("R3", res_vec, 128'd0);
        apply(32'hFFFF_FFFF, PAT);
        chk("R3", res_vec, 128'd0);

        // R9: destination field passes through
        for (int v = 0; v < 32; v += 7) begin
            apply(mk(1'b1, 5'd2, 5'd9, v[4:0]), PAT);
            chk("R9", {123'b0, dst_idx}, {123'b0, v[4:0]});
        end

        // R10: source register field ignored
        apply(mk(1'b0, 5'd5, 5'd0, 5'd1), PAT);
        lo_r = res_vec;
        apply(mk(1'b0, 5'd5, 5'd31, 5'd1), PAT);
        chk("R10", res_vec, lo_r);
        chk("R10", {127'b0, vld}, 128'd1);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule